// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block is a single-channel transfer engine that follows a chain of descriptors stored in memory. Software places descriptors in memory, writes the address of the first one into the descriptor address register, and issues a start command. The engine fetches each five-word descriptor and loads its control word as the active channel setup. It then copies the requested number of units from the source to the destination, one unit per read/write pair, and either follows the next pointer or stops.

Each descriptor carries its own flags: a link flag, enables for the error, per-descriptor completion and end-of-chain interrupts, and burst settings for the memory port. An interrupt reaches the output only when the global enable bit of the control word currently loaded is set. A misaligned source or destination address stops the channel and sets an alignment error flag. A halt command stops the chain at once.

Top module: `sgw_chain_walker`

## Requirements
- R1: During and after reset the engine is idle: busy=0, irq=0, align_err=0, and neither mem_rd nor mem_we is asserted until a start command.
- R2: A command write (cmd_wr=1) acts on the channel only when cmd_mask=1 in the same write. cmd_start=1 starts fetching from the descriptor address register. A write with cmd_mask=0 has no effect.
- R3: A descriptor is five 32-bit words at byte offsets +0 control, +4 source, +8 destination, +12 count/flags, +16 next pointer. The engine reads them in that order with mem_size=2.
- R4: Each fetched control word replaces the whole ctrl_word output. Bit 0 is the global interrupt enable. Bits [2:1] select the unit width: 0=1, 1=2, 2=4, 3=8 bytes.
- R5: Count/flags bits [15:0] give the count in units. Each unit reads 2^w bytes at the source and writes them at the destination, and both addresses then advance by 2^w. In total count<<w bytes move. A count of 0 moves nothing.
- R6: Count/flags bit 31 is the link flag. When it is set, the next descriptor is fetched from the next pointer. When it is clear, busy drops after this descriptor.
- R7: desc_addr shows the address of the current descriptor. remain_cnt shows the units left in it and drops by one after each unit write.
- R8: irq is a one-cycle pulse. It fires once when a descriptor completes if bit 29 (per-descriptor completion enable) is set, or if bit 28 (end-of-chain enable) is set and the link flag is clear. It fires only when the global enable is set.
- R9: If the source or destination is not a multiple of 2^w, the engine sets align_err, transfers no unit and drops busy. It pulses irq if bit 30 (error enable) and the global enable are set. align_err clears on the next start.
- R10: A halt (cmd_wr=1, cmd_mask=1, cmd_start=0) while busy makes the engine idle on the next cycle, with no further memory access and no interrupt. A halt in the completion cycle (the cycle after the final unit write) suppresses that descriptor's interrupt and the link follow.
- R11: During unit reads and writes, mem_burst_len shows count/flags bits [27:26] and mem_burst_en shows bit 25 of the current descriptor. Both read zero otherwise.
- R12: While busy, writes to the descriptor address register and further start commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_wr | input | 1 | Write strobe for the descriptor address register |
| desc_wdata | input | AW | First descriptor address |
| cmd_wr | input | 1 | Command write strobe |
| cmd_start | input | 1 | Start (1) or halt (0) value of the command write |
| cmd_mask | input | 1 | Mask enable; the command acts only when set |
| desc_addr | output | AW | Address of the current descriptor |
| remain_cnt | output | CW | Units left in the current descriptor |
| ctrl_word | output | 32 | Control word loaded from the current descriptor |
| busy | output | 1 | Chain running |
| align_err | output | 1 | Alignment error flag |
| irq | output | 1 | Interrupt pulse |
| mem_rd | output | 1 | Memory read request; data returns the next cycle |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | AW | Memory byte address |
| mem_size | output | 2 | Access size code, 2^size bytes |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after mem_rd |
| mem_burst_len | output | 2 | Burst size of the current descriptor |
| mem_burst_en | output | 1 | Burst enable of the current descriptor |

## Verification
The case that needs care is a halt that arrives in the same cycle as a descriptor's completion. In that cycle the engine would otherwise pulse the interrupt and follow a valid link. The bench waits at the falling edge for the final unit write (mem_we with remain_cnt at 1) and drives the halt into the following cycle. It then confirms that no interrupt pulse appears, that desc_addr still names the halted descriptor, and that no further memory read occurs. A second halt lands in the middle of a transfer, and the bench judges it by the frozen remain_cnt and the write count.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int DESC_WORDS = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_FREQ, S_FCAP, S_CHK, S_RD, S_RCAP, S_WR, S_DONE
  } sgw_state_t;

  // count/flags word bits [31:25], packed in bit order
  typedef struct packed {
    logic       link;
    logic       err_ie;
    logic       tc_ie;
    logic       eot_ie;
    logic [1:0] burst_len;
    logic       burst_en;
  } sgw_flags_t;
endpackage

// File: rtl/sgw_cmd_dec.sv
module sgw_cmd_dec (
  input  logic cmd_wr,
  input  logic cmd_start,
  input  logic cmd_mask,
  output logic go,
  output logic halt
);
  always_comb begin
    go   = cmd_wr & cmd_mask & cmd_start;
    halt = cmd_wr & cmd_mask & ~cmd_start;
  end
endmodule

// File: rtl/sgw_align_chk.sv
module sgw_align_chk #(
  parameter int AW = 32
) (
  input  logic [1:0]    wsel,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  output logic          misaligned
);
  logic [AW-1:0] low_mask;
  always_comb begin
    low_mask   = (AW'(1) << wsel) - AW'(1);
    misaligned = |((src | dst) & low_mask);
  end
endmodule

// File: rtl/sgw_irq_qual.sv
module sgw_irq_qual
  import sgw_pkg::*;
(
  input  logic       global_en,
  input  sgw_flags_t flags,
  input  logic       ev_done,
  input  logic       ev_err,
  output logic       irq_set
);
  logic done_hit;
  always_comb begin
    done_hit = ev_done & (flags.tc_ie | (flags.eot_ie & ~flags.link));
    irq_set  = global_en & (done_hit | (ev_err & flags.err_ie));
  end
endmodule

// File: rtl/sgw_chain_walker.sv
module sgw_chain_walker
  import sgw_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desc_wr,
  input  logic [AW-1:0] desc_wdata,
  input  logic          cmd_wr,
  input  logic          cmd_start,
  input  logic          cmd_mask,
  output logic [AW-1:0] desc_addr,
  output logic [CW-1:0] remain_cnt,
  output logic [31:0]   ctrl_word,
  output logic          busy,
  output logic          align_err,
  output logic          irq,
  output logic          mem_rd,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [1:0]    mem_burst_len,
  output logic          mem_burst_en
);
  localparam int WIW = $clog2(DESC_WORDS);
  localparam logic [WIW-1:0] LAST_W = WIW'(DESC_WORDS - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_i = rs_q[1];

  sgw_state_t    st_q, st_d;
  logic [WIW-1:0] widx_q, widx_d;
  logic [AW-1:0] dsc_q, dsc_d, src_q, src_d, dst_q, dst_d, nxt_q, nxt_d;
  logic [31:0]   ctrl_q, ctrl_d;
  sgw_flags_t    flg_q, flg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] dat_q, dat_d;
  logic          aerr_q, aerr_d, irq_q, irq_d;
  logic          go, halt, misal, ev_done, ev_err;
  logic [1:0]    wsel;
  logic [AW-1:0] ustep;

  assign wsel  = ctrl_q[2:1];
  assign ustep = AW'(1) << wsel;

  sgw_cmd_dec u_cmd (
    .cmd_wr(cmd_wr), .cmd_start(cmd_start), .cmd_mask(cmd_mask),
    .go(go), .halt(halt)
  );

  sgw_align_chk #(.AW(AW)) u_align (
    .wsel(wsel), .src(src_q), .dst(dst_q), .misaligned(misal)
  );

  sgw_irq_qual u_irq (
    .global_en(ctrl_q[0]), .flags(flg_q), .ev_done(ev_done),
    .ev_err(ev_err), .irq_set(irq_d)
  );

  // next-state logic
  always_comb begin
    st_d = st_q; widx_d = widx_q; dsc_d = dsc_q; src_d = src_q;
    dst_d = dst_q; nxt_d = nxt_q; ctrl_d = ctrl_q; flg_d = flg_q;
    cnt_d = cnt_q; dat_d = dat_q; aerr_d = aerr_q;
    ev_done = 1'b0; ev_err = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (desc_wr) dsc_d = desc_wdata;
        if (go) begin
          st_d = S_FREQ; widx_d = '0; aerr_d = 1'b0;
        end
      end
      S_FREQ: st_d = S_FCAP;
      S_FCAP: begin
        case (widx_q)
          WIW'(0): ctrl_d = mem_rdata[31:0];
          WIW'(1): src_d  = mem_rdata[AW-1:0];
          WIW'(2): dst_d  = mem_rdata[AW-1:0];
          WIW'(3): begin
            flg_d = sgw_flags_t'(mem_rdata[31:25]);
            cnt_d = mem_rdata[CW-1:0];
          end
          default: nxt_d = mem_rdata[AW-1:0];
        endcase
        if (widx_q == LAST_W) st_d = S_CHK;
        else begin
          widx_d = widx_q + WIW'(1); st_d = S_FREQ;
        end
      end
      S_CHK: begin
        if (misal) begin
          aerr_d = 1'b1; ev_err = 1'b1; st_d = S_IDLE;
        end else if (cnt_q == '0) st_d = S_DONE;
        else st_d = S_RD;
      end
      S_RD:   st_d = S_RCAP;
      S_RCAP: begin
        dat_d = mem_rdata; st_d = S_WR;
      end
      S_WR: begin
        src_d = src_q + ustep;
        dst_d = dst_q + ustep;
        cnt_d = cnt_q - CW'(1);
        st_d  = (cnt_q == CW'(1)) ? S_DONE : S_RD;
      end
      S_DONE: begin
        ev_done = 1'b1;
        if (flg_q.link) begin
          dsc_d = nxt_q; widx_d = '0; st_d = S_FREQ;
        end else st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
    // halt outranks every other event of the cycle
    if (halt && st_q != S_IDLE) begin
      st_d = S_IDLE; widx_d = widx_q; dsc_d = dsc_q; src_d = src_q;
      dst_d = dst_q; nxt_d = nxt_q; ctrl_d = ctrl_q; flg_d = flg_q;
      cnt_d = cnt_q; dat_d = dat_q; aerr_d = aerr_q;
      ev_done = 1'b0; ev_err = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q <= S_IDLE; widx_q <= '0; dsc_q <= '0; src_q <= '0;
      dst_q <= '0; nxt_q <= '0; ctrl_q <= '0; flg_q <= '0;
      cnt_q <= '0; dat_q <= '0; aerr_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      st_q <= st_d; widx_q <= widx_d; dsc_q <= dsc_d; src_q <= src_d;
      dst_q <= dst_d; nxt_q <= nxt_d; ctrl_q <= ctrl_d; flg_q <= flg_d;
      cnt_q <= cnt_d; dat_q <= dat_d; aerr_q <= aerr_d; irq_q <= irq_d;
    end
  end

  // outputs
  logic unit_phase;
  always_comb begin
    unit_phase    = (st_q == S_RD) || (st_q == S_RCAP) || (st_q == S_WR);
    mem_rd        = ((st_q == S_FREQ) || (st_q == S_RD)) && !halt;
    mem_we        = (st_q == S_WR) && !halt;
    mem_addr      = (st_q == S_FREQ) ? dsc_q + AW'({widx_q, 2'b00}) :
                    (st_q == S_WR)   ? dst_q : src_q;
    mem_size      = (st_q == S_FREQ) ? 2'd2 : wsel;
    mem_wdata     = dat_q;
    mem_burst_len = unit_phase ? flg_q.burst_len : 2'b00;
    mem_burst_en  = unit_phase & flg_q.burst_en;
    desc_addr     = dsc_q;
    remain_cnt    = cnt_q;
    ctrl_word     = ctrl_q;
    busy          = (st_q != S_IDLE);
    align_err     = aerr_q;
    irq           = irq_q;
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!busy && !go) |=> !busy);
  // R7
  remain_step_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    mem_we |=> (remain_cnt == $past(remain_cnt) - CW'(1)));
  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    irq |=> !irq);
  // R9
  align_stop_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(align_err) |-> !busy);
  // R9
  write_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    mem_we |-> ((mem_addr & ((AW'(1) << mem_size) - AW'(1))) == '0));
  // R10
  halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (busy && halt) |=> (!busy && !mem_rd && !mem_we && !irq));
endmodule

// File: tb/tb_sgw_chain_walker.sv
module tb_sgw_chain_walker;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, DW = 64, CW = 16;
  localparam logic [31:0] G = 32'h1;
  localparam logic [31:0] LNK = 32'h8000_0000, ERI = 32'h4000_0000;
  localparam logic [31:0] TCI = 32'h2000_0000, EOI = 32'h1000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic desc_wr = 1'b0, cmd_wr = 1'b0, cmd_start = 1'b0, cmd_mask = 1'b0;
  logic [AW-1:0] desc_wdata = '0;
  logic [AW-1:0] desc_addr, mem_addr;
  logic [CW-1:0] remain_cnt;
  logic [31:0] ctrl_word;
  logic busy, align_err, irq, mem_rd, mem_we, mem_burst_en;
  logic [1:0] mem_size, mem_burst_len;
  logic [DW-1:0] mem_wdata, mem_rdata;

  int checks = 0, errors = 0;
  int irq_cnt = 0, wr_cnt = 0, rd_cnt = 0;
  logic [AW-1:0] rd_log [0:255];
  logic [7:0] mem [0:4095];

  always #(CLK_PERIOD/2) clk = ~clk;

  sgw_chain_walker #(.AW(AW), .DW(DW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .desc_wr(desc_wr), .desc_wdata(desc_wdata),
    .cmd_wr(cmd_wr), .cmd_start(cmd_start), .cmd_mask(cmd_mask),
    .desc_addr(desc_addr), .remain_cnt(remain_cnt), .ctrl_word(ctrl_word),
    .busy(busy), .align_err(align_err), .irq(irq), .mem_rd(mem_rd),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_burst_len(mem_burst_len), .mem_burst_en(mem_burst_en)
  );

  // memory model with one-cycle read latency
  always @(posedge clk) begin
    logic [DW-1:0] r;
    r = '0;
    if (mem_rd) begin
      for (int b = 0; b < 8; b++)
        if (b < (1 << mem_size)) r[8*b +: 8] = mem[(mem_addr + b) & 32'hFFF];
      mem_rdata <= r;
      rd_log[rd_cnt % 256] <= mem_addr;
      rd_cnt <= rd_cnt + 1;
    end
    if (mem_we) begin
      for (int b = 0; b < 8; b++)
        if (b < (1 << mem_size)) mem[(mem_addr + b) & 32'hFFF] <= mem_wdata[8*b +: 8];
      wr_cnt <= wr_cnt + 1;
    end
    if (irq) irq_cnt <= irq_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke32(input int a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) mem[(a + b) & 12'hFFF] = v[8*b +: 8];
  endtask

  task automatic mk_desc(input int a, input logic [31:0] c, input logic [31:0] s,
                         input logic [31:0] d, input logic [31:0] f, input logic [31:0] n);
    poke32(a, c); poke32(a + 4, s); poke32(a + 8, d); poke32(a + 12, f); poke32(a + 16, n);
  endtask

  task automatic cmd(input logic st, input logic mk);
    @(negedge clk); cmd_wr = 1'b1; cmd_start = st; cmd_mask = mk;
    @(negedge clk); cmd_wr = 1'b0; cmd_start = 1'b0; cmd_mask = 1'b0;
  endtask

  task automatic launch(input logic [AW-1:0] a);
    @(negedge clk); desc_wr = 1'b1; desc_wdata = a;
    @(negedge clk); desc_wr = 1'b0;
    cmd(1'b1, 1'b1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_dst();
    for (int i = 'h400; i < 'h600; i++) mem[i] = 8'h00;
  endtask

  function automatic bit copied(input int s, input int d, input int n);
    for (int i = 0; i < n; i++) if (mem[d + i] !== mem[s + i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !irq && !align_err && !mem_rd && !mem_we, "R1 reset idle",
        {busy, irq, align_err, mem_rd, mem_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !mem_rd && !mem_we, "R1 after release", {busy, mem_rd, mem_we}, 0);
  endtask

  task automatic t_single();
    int i0, r0;
    clear_dst();
    mk_desc('h800, G | (2 << 1), 'h100, 'h400, EOI | 4, 0);
    i0 = irq_cnt; r0 = rd_cnt;
    launch('h800);
    wait_idle();
    chk(copied('h100, 'h400, 16), "R5 single 32-bit copy", mem['h40F], mem['h10F]);
    chk(mem['h410] == 0, "R5 no byte past length", mem['h410], 0);
    chk(irq_cnt - i0 == 1, "R8 end-of-chain irq", irq_cnt - i0, 1);
    chk(ctrl_word == (G | (2 << 1)), "R4 control loaded", ctrl_word, G | (2 << 1));
    chk(desc_addr == 'h800 && remain_cnt == 0, "R7 final desc/remain", {desc_addr, 16'(remain_cnt)}, 'h800_0000);
    for (int k = 0; k < 5; k++)
      chk(rd_log[(r0 + k) % 256] == 'h800 + 4 * k, "R3 fetch order", rd_log[(r0 + k) % 256], 'h800 + 4 * k);
    chk(!align_err, "R9 cleared by start", align_err, 0);
  endtask

  task automatic t_chain();
    int i0;
    clear_dst();
    mk_desc('h820, G | (0 << 1), 'h140, 'h440, LNK | TCI | 3, 'h840);
    mk_desc('h840, G | (3 << 1), 'h160, 'h460, LNK | TCI | 2, 'h860);
    mk_desc('h860, G | (1 << 1), 'h180, 'h480, TCI | EOI | 5, 0);
    i0 = irq_cnt;
    launch('h820);
    wait_idle();
    chk(copied('h140, 'h440, 3) && mem['h443] == 0, "R5 8-bit unit", mem['h443], 0);
    chk(copied('h160, 'h460, 16) && mem['h470] == 0, "R5 64-bit unit", mem['h470], 0);
    chk(copied('h180, 'h480, 10) && mem['h48A] == 0, "R6 linked third copy", mem['h48A], 0);
    chk(irq_cnt - i0 == 3, "R8 one pulse per descriptor", irq_cnt - i0, 3);
    chk(ctrl_word == (G | (1 << 1)), "R4 last control replaces", ctrl_word, G | (1 << 1));
    chk(desc_addr == 'h860, "R6 R7 desc_addr follows link", desc_addr, 'h860);
  endtask

  task automatic t_count0_and_gate();
    int i0, w0;
    clear_dst();
    mk_desc('h880, G | (2 << 1), 'h100, 'h4A0, TCI | 0, 0);
    i0 = irq_cnt; w0 = wr_cnt;
    launch('h880); wait_idle();
    chk(wr_cnt == w0, "R5 zero count no write", wr_cnt - w0, 0);
    chk(irq_cnt - i0 == 1, "R8 zero count completes", irq_cnt - i0, 1);
    mk_desc('h8A0, (2 << 1), 'h100, 'h4B0, TCI | EOI | 2, 0);
    i0 = irq_cnt;
    launch('h8A0); wait_idle();
    chk(irq_cnt == i0, "R8 global enable off", irq_cnt - i0, 0);
    chk(copied('h100, 'h4B0, 8), "R5 copy without irq", mem['h4B7], mem['h107]);
  endtask

  task automatic t_align();
    int i0, w0;
    clear_dst();
    mk_desc('h8C0, G | (2 << 1), 'h102, 'h4C0, ERI | EOI | 2, 0);
    i0 = irq_cnt; w0 = wr_cnt;
    launch('h8C0); wait_idle();
    chk(align_err && !busy, "R9 src misaligned stops", {align_err, busy}, 2'b10);
    chk(wr_cnt == w0, "R9 no unit moved", wr_cnt - w0, 0);
    chk(irq_cnt - i0 == 1, "R9 error irq", irq_cnt - i0, 1);
    mk_desc('h8E0, G | (2 << 1), 'h100, 'h4C2, EOI | 2, 0);
    i0 = irq_cnt;
    launch('h8E0); wait_idle();
    chk(align_err && irq_cnt == i0, "R9 dst misaligned no err enable", irq_cnt - i0, 0);
  endtask

  task automatic t_mask();
    int r0;
    r0 = rd_cnt;
    @(negedge clk); desc_wr = 1'b1; desc_wdata = 'h800;
    @(negedge clk); desc_wr = 1'b0;
    cmd(1'b1, 1'b0);
    repeat (5) @(negedge clk);
    chk(!busy && rd_cnt == r0, "R2 mask clear ignored", {busy, 8'(rd_cnt - r0)}, 0);
  endtask

  task automatic t_halt_mid();
    int i0, w0;
    clear_dst();
    mk_desc('h900, G, 'h100, 'h4D0, TCI | EOI | 20, 0);
    i0 = irq_cnt; w0 = wr_cnt;
    launch('h900);
    for (int i = 0; i < 200 && !mem_we; i++) @(negedge clk);
    @(posedge clk);
    @(negedge clk); cmd_wr = 1'b1; cmd_start = 1'b0; cmd_mask = 1'b1;
    @(negedge clk); cmd_wr = 1'b0; cmd_mask = 1'b0;
    chk(!busy, "R10 halt idles next cycle", busy, 0);
    repeat (6) @(negedge clk);
    chk(remain_cnt == 19, "R7 remain after one unit", remain_cnt, 19);
    chk(wr_cnt - w0 == 1, "R10 no write after halt", wr_cnt - w0, 1);
    chk(irq_cnt == i0, "R10 no irq on halt", irq_cnt - i0, 0);
  endtask

  task automatic t_halt_done();
    int i0, r0;
    clear_dst();
    mk_desc('h920, G | (2 << 1), 'h100, 'h4F0, LNK | TCI | EOI | 2, 'h800);
    i0 = irq_cnt;
    launch('h920);
    for (int i = 0; i < 200 && !(mem_we && remain_cnt == 1); i++) @(negedge clk);
    @(posedge clk);
    @(negedge clk); cmd_wr = 1'b1; cmd_start = 1'b0; cmd_mask = 1'b1;
    r0 = rd_cnt;
    @(negedge clk); cmd_wr = 1'b0; cmd_mask = 1'b0;
    repeat (6) @(negedge clk);
    chk(irq_cnt == i0, "R10 halt in completion cycle masks irq", irq_cnt - i0, 0);
    chk(!busy && desc_addr == 'h920, "R10 link not followed", desc_addr, 'h920);
    chk(rd_cnt == r0, "R10 no fetch after halt", rd_cnt - r0, 0);
    chk(copied('h100, 'h4F0, 8), "R10 both units done", mem['h4F7], mem['h107]);
  endtask

  task automatic t_burst();
    bit seen;
    seen = 1'b0;
    clear_dst();
    mk_desc('h940, G | (2 << 1), 'h100, 'h500, EOI | (2 << 26) | (1 << 25) | 2, 0);
    launch('h940);
    for (int i = 0; i < 200 && busy; i++) begin
      if (mem_rd && mem_addr == 'h100 && !seen) begin
        seen = 1'b1;
        chk(mem_burst_len == 2 && mem_burst_en, "R11 burst on unit read", {mem_burst_len, mem_burst_en}, 3'b101);
      end
      if (mem_rd && mem_addr == 'h940)
        chk(mem_burst_len == 0 && !mem_burst_en, "R11 no burst on fetch", {mem_burst_len, mem_burst_en}, 0);
      @(negedge clk);
    end
    chk(seen, "R11 unit read observed", seen, 1);
    wait_idle();
  endtask

  task automatic t_busy_ignore();
    int i0;
    clear_dst();
    mk_desc('h960, G, 'h100, 'h520, EOI | 6, 0);
    i0 = irq_cnt;
    launch('h960);
    repeat (3) @(negedge clk);
    desc_wr = 1'b1; desc_wdata = 'h800;
    @(negedge clk); desc_wr = 1'b0;
    cmd(1'b1, 1'b1);
    wait_idle();
    repeat (4) @(negedge clk);
    chk(desc_addr == 'h960, "R12 address write ignored while busy", desc_addr, 'h960);
    chk(!busy && irq_cnt - i0 == 1, "R12 start ignored while busy", irq_cnt - i0, 1);
    chk(copied('h100, 'h520, 6), "R12 transfer intact", mem['h525], mem['h105]);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    for (int i = 'h100; i < 'h200; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    t_reset();
    t_align();
    t_single();
    t_chain();
    t_count0_and_gate();
    t_mask();
    t_halt_mid();
    t_halt_done();
    t_burst();
    t_busy_ignore();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule